// File: doc/BRIEF.md
# Super I/O Configuration Register Unit

This block holds the configuration state of a legacy peripheral controller. Software reaches it through two byte-wide ports. The index port selects one internal register and the data port reads or writes that register. There are three registers: a function-enable register, a function-address register and a power/test register. On reset they load from a 32-entry table chosen by a 5-bit strap input.

The index port also supports identification. After reset, the first reads of the index port return a fixed signature byte and then a zero byte. Every later read returns the currently selected index.

The block decodes the three registers into flags, I/O base addresses and interrupt numbers for these functions:
- one parallel port
- two UARTs
- one floppy controller
- one IDE controller

The decoded values are registered outputs that neighbouring logic uses to place those peripherals.

Top module: `sio_cfg_unit`

## Requirements
- R1: `port_sel` = 0 addresses the index port and `port_sel` = 1 addresses the data port; every access is one byte wide.
- R2: An index-port write stores `wdata` as the selected index. Every index-port read after it returns that index until the next index-port write.
- R3: After reset, successive index-port reads return 0x88, then 0x00, then the selected index on every further read. The sequence stays in the last state.
- R4: Selected indices 0, 1 and 2 map to the enable, address and power/test registers. A data write with any other index changes no register. A data read with any other index returns 0x00.
- R5: Reset sets the selected index to 0 and loads the three registers from the strap table. Strap 1 gives enable 0x4F, address 0x11 and power 0x00. Strap 31 gives enable 0x00, address 0x10 and power 0x02.
- R6: The enable register bits decode as follows:
  - bit 0: parallel enable
  - bit 1: UART0 enable
  - bit 2: UART1 enable
  - bit 3: floppy enable
  - bit 5: floppy base, 1 gives 0x370 and 0 gives 0x3F0
  - bit 6: IDE enable
  - bit 7: IDE base, 1 gives 0x170 and 0 gives 0x1F0

  The IDE control base is the IDE base plus 0x206. The IDE IRQ is 14 and the floppy IRQ is 6.
- R7: The parallel port base comes from address bits [1:0]: code 0 gives 0x378, code 1 gives 0x3BC, code 2 gives 0x278 and code 3 gives 0x000. Code 0 gives IRQ 7 when power bit 3 is 1 and IRQ 5 otherwise. Code 1 gives IRQ 7, code 2 gives IRQ 5 and code 3 gives IRQ 0.
- R8: UART n takes code c from address bits [2n+3:2n+2]. Code 0 gives base 0x3F8 and code 1 gives 0x2F8. For codes 2 and 3, address bits [7:6] pick entry k from a list:
  - code 2: 0x3E8, 0x338, 0x2E8, 0x220
  - code 3: 0x2E8, 0x238, 0x2E0, 0x228

  The IRQ is 3 for an odd code and 4 for an even code.
- R9: Read data is combinational in the cycle of the read strobe. Decoded outputs change on the clock edge after the edge that writes the register.
- R10: When read and write strobes are both high, the access acts as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap | input | 5 | Reset-value selector |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| par_en | output | 1 | Parallel port enable |
| par_base | output | 16 | Parallel port base |
| par_irq | output | 4 | Parallel port IRQ |
| uart0_en | output | 1 | UART0 enable |
| uart0_base | output | 16 | UART0 base |
| uart0_irq | output | 4 | UART0 IRQ |
| uart1_en | output | 1 | UART1 enable |
| uart1_base | output | 16 | UART1 base |
| uart1_irq | output | 4 | UART1 IRQ |
| fdc_en | output | 1 | Floppy enable |
| fdc_base | output | 16 | Floppy base |
| fdc_irq | output | 4 | Floppy IRQ |
| ide_en | output | 1 | IDE enable |
| ide_base | output | 16 | IDE command base |
| ide_ctl_base | output | 16 | IDE control base |
| ide_irq | output | 4 | IDE IRQ |

## Verification
Two strap values are tried: strap 1 and strap 31. They have opposite enable patterns, so a misloaded table row or a missing reset branch shows up in the register reads and in the decoded outputs.

The address register is written with the following values:
- each parallel code, with power bit 3 both set and clear
- UART codes 2 and 3 with several values of bits [7:6], which separates the two lists and the entry selection from the parity rule for the IRQ
- an enable pattern with the upper bits set, which moves the floppy and IDE bases

Index reads are checked through the full identification sequence. Further accesses check an out-of-range index, simultaneous read and write strobes, and the one-edge lag of the decoded outputs.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 16;
    localparam int IRQ_W    = 4;
    localparam int STRAP_W  = 5;
    localparam int NUM_REGS = 3;
    localparam int NUM_UART = 2;

    localparam logic [DATA_W-1:0] ID_SIGNATURE = 8'h88;

    typedef enum logic [1:0] {
        ID_SIG   = 2'd0,
        ID_ZERO  = 2'd1,
        ID_INDEX = 2'd2
    } id_step_e;

    typedef struct packed {
        logic                            par_en;
        logic [ADDR_W-1:0]               par_base;
        logic [IRQ_W-1:0]                par_irq;
        logic [NUM_UART-1:0]             uart_en;
        logic [NUM_UART-1:0][ADDR_W-1:0] uart_base;
        logic [NUM_UART-1:0][IRQ_W-1:0]  uart_irq;
        logic                            fdc_en;
        logic [ADDR_W-1:0]               fdc_base;
        logic                            ide_en;
        logic [ADDR_W-1:0]               ide_base;
    } dec_t;

    function automatic logic [DATA_W-1:0] strap_enable(input logic [STRAP_W-1:0] s);
        logic [DATA_W-1:0] v;
        if (s <= 5'd5)       v = 8'h4F;
        else if (s <= 5'd11) v = 8'h4B;
        else if (s <= 5'd15) v = 8'h0F;
        else if (s <= 5'd19) v = 8'h49;
        else if (s <= 5'd23) v = 8'h07;
        else if (s <= 5'd29) v = 8'h47;
        else if (s == 5'd30) v = 8'h08;
        else                 v = 8'h00;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] strap_address(input logic [STRAP_W-1:0] s);
        logic [DATA_W-1:0] v;
        case (s)
            5'd0, 5'd12, 5'd20, 5'd24, 5'd30, 5'd31:          v = 8'h10;
            5'd1, 5'd2, 5'd13, 5'd21, 5'd25, 5'd26:           v = 8'h11;
            5'd3, 5'd14, 5'd22, 5'd27:                        v = 8'h39;
            5'd4, 5'd15, 5'd23, 5'd28:                        v = 8'h24;
            5'd5, 5'd29:                                      v = 8'h38;
            5'd7, 5'd8, 5'd17, 5'd18:                         v = 8'h01;
            5'd9:                                             v = 8'h09;
            5'd10, 5'd11:                                     v = 8'h08;
            default:                                          v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] strap_power(input logic [STRAP_W-1:0] s);
        return (s == 5'd31) ? 8'h02 : 8'h00;
    endfunction

    function automatic logic [DATA_W-1:0] strap_reg(input logic [STRAP_W-1:0] s, input int n);
        logic [DATA_W-1:0] v;
        case (n)
            0:       v = strap_enable(s);
            1:       v = strap_address(s);
            default: v = strap_power(s);
        endcase
        return v;
    endfunction

    function automatic logic [ADDR_W-1:0] uart_alt_base(input logic odd, input logic [1:0] k);
        logic [ADDR_W-1:0] v;
        if (!odd) begin
            case (k)
                2'd0: v = 16'h03E8;
                2'd1: v = 16'h0338;
                2'd2: v = 16'h02E8;
                default: v = 16'h0220;
            endcase
        end else begin
            case (k)
                2'd0: v = 16'h02E8;
                2'd1: v = 16'h0238;
                2'd2: v = 16'h02E0;
                default: v = 16'h0228;
            endcase
        end
        return v;
    endfunction

    function automatic dec_t decode_cfg(input logic [DATA_W-1:0] en_r,
                                        input logic [DATA_W-1:0] ad_r,
                                        input logic [DATA_W-1:0] pw_r);
        dec_t d;
        logic [1:0] code;
        d.par_en = en_r[0];
        case (ad_r[1:0])
            2'd0: begin d.par_base = 16'h0378; d.par_irq = pw_r[3] ? 4'd7 : 4'd5; end
            2'd1: begin d.par_base = 16'h03BC; d.par_irq = 4'd7; end
            2'd2: begin d.par_base = 16'h0278; d.par_irq = 4'd5; end
            default: begin d.par_base = 16'h0000; d.par_irq = 4'd0; end
        endcase
        for (int n = 0; n < NUM_UART; n++) begin
            code = ad_r[2*n+2 +: 2];
            d.uart_en[n] = en_r[1+n];
            case (code)
                2'd0:    d.uart_base[n] = 16'h03F8;
                2'd1:    d.uart_base[n] = 16'h02F8;
                default: d.uart_base[n] = uart_alt_base(code[0], ad_r[7:6]);
            endcase
            d.uart_irq[n] = code[0] ? 4'd3 : 4'd4;
        end
        d.fdc_en   = en_r[3];
        d.fdc_base = en_r[5] ? 16'h0370 : 16'h03F0;
        d.ide_en   = en_r[6];
        d.ide_base = en_r[7] ? 16'h0170 : 16'h01F0;
        return d;
    endfunction

endpackage

// File: rtl/sio_cfg_regfile.sv
module sio_cfg_regfile
    import sio_cfg_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NR = NUM_REGS,
    parameter int SW = STRAP_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SW-1:0]        strap,
    input  logic                 port_sel,
    input  logic                 wr_en,
    input  logic                 rd_en,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic [NR-1:0][DW-1:0] regs_q,
    output logic [DW-1:0]        idx_q,
    output id_step_e             step_q
);

    logic idx_wr, dat_wr, idx_rd, dat_rd;

    assign idx_wr = wr_en && !port_sel;
    assign dat_wr = wr_en &&  port_sel;
    assign idx_rd = rd_en && !wr_en && !port_sel;
    assign dat_rd = rd_en && !wr_en &&  port_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q  <= '0;
            step_q <= ID_SIG;
        end else if (idx_wr) begin
            idx_q  <= wdata;
            step_q <= ID_INDEX;
        end else if (idx_rd) begin
            case (step_q)
                ID_SIG:  step_q <= ID_ZERO;
                default: step_q <= ID_INDEX;
            endcase
        end
    end

    for (genvar g = 0; g < NR; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= strap_reg(strap, g);
            else if (dat_wr && idx_q == DW'(g))
                regs_q[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (idx_rd) begin
            case (step_q)
                ID_SIG:  rdata = ID_SIGNATURE;
                ID_ZERO: rdata = '0;
                default: rdata = idx_q;
            endcase
        end else if (dat_rd) begin
            for (int i = 0; i < NR; i++)
                if (idx_q == DW'(i)) rdata = regs_q[i];
        end
    end

endmodule

// File: rtl/sio_cfg_decode.sv
module sio_cfg_decode
    import sio_cfg_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NR = NUM_REGS,
    parameter int SW = STRAP_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [SW-1:0]         strap,
    input  logic [NR-1:0][DW-1:0] regs_q,
    output dec_t                  dec_q
);

    always_ff @(posedge clk) begin
        if (rst)
            dec_q <= decode_cfg(strap_enable(strap), strap_address(strap), strap_power(strap));
        else
            dec_q <= decode_cfg(regs_q[0], regs_q[1], regs_q[2]);
    end

endmodule

// File: rtl/sio_cfg_unit.sv
module sio_cfg_unit
    import sio_cfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [STRAP_W-1:0] strap,
    input  logic               port_sel,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               par_en,
    output logic [ADDR_W-1:0]  par_base,
    output logic [IRQ_W-1:0]   par_irq,
    output logic               uart0_en,
    output logic [ADDR_W-1:0]  uart0_base,
    output logic [IRQ_W-1:0]   uart0_irq,
    output logic               uart1_en,
    output logic [ADDR_W-1:0]  uart1_base,
    output logic [IRQ_W-1:0]   uart1_irq,
    output logic               fdc_en,
    output logic [ADDR_W-1:0]  fdc_base,
    output logic [IRQ_W-1:0]   fdc_irq,
    output logic               ide_en,
    output logic [ADDR_W-1:0]  ide_base,
    output logic [ADDR_W-1:0]  ide_ctl_base,
    output logic [IRQ_W-1:0]   ide_irq
);

    localparam logic [ADDR_W-1:0] IDE_CTL_OFS = 16'h0206;
    localparam logic [IRQ_W-1:0]  FDC_IRQ_NUM = 4'd6;
    localparam logic [IRQ_W-1:0]  IDE_IRQ_NUM = 4'd14;

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic [DATA_W-1:0]               idx_q;
    id_step_e                        step_q;
    dec_t                            dec_q;

    sio_cfg_regfile u_regs (
        .clk(clk), .rst(rst), .strap(strap), .port_sel(port_sel),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .regs_q(regs_q), .idx_q(idx_q), .step_q(step_q)
    );

    sio_cfg_decode u_dec (
        .clk(clk), .rst(rst), .strap(strap), .regs_q(regs_q), .dec_q(dec_q)
    );

    assign par_en       = dec_q.par_en;
    assign par_base     = dec_q.par_base;
    assign par_irq      = dec_q.par_irq;
    assign uart0_en     = dec_q.uart_en[0];
    assign uart0_base   = dec_q.uart_base[0];
    assign uart0_irq    = dec_q.uart_irq[0];
    assign uart1_en     = dec_q.uart_en[1];
    assign uart1_base   = dec_q.uart_base[1];
    assign uart1_irq    = dec_q.uart_irq[1];
    assign fdc_en       = dec_q.fdc_en;
    assign fdc_base     = dec_q.fdc_base;
    assign fdc_irq      = FDC_IRQ_NUM;
    assign ide_en       = dec_q.ide_en;
    assign ide_base     = dec_q.ide_base;
    assign ide_ctl_base = dec_q.ide_base + IDE_CTL_OFS;
    assign ide_irq      = IDE_IRQ_NUM;

endmodule

// File: rtl/sio_cfg_checker.sv
module sio_cfg_checker
    import sio_cfg_pkg::*;
(
    input logic                            clk,
    input logic                            rst,
    input logic                            port_sel,
    input logic                            wr_en,
    input logic                            rd_en,
    input logic [DATA_W-1:0]               wdata,
    input logic [DATA_W-1:0]               rdata,
    input logic [NUM_REGS-1:0][DATA_W-1:0] regs_q,
    input logic [DATA_W-1:0]               idx_q,
    input logic [1:0]                      step_q,
    input logic                            fdc_en,
    input logic [ADDR_W-1:0]               ide_base,
    input logic [ADDR_W-1:0]               ide_ctl_base,
    input logic [IRQ_W-1:0]                uart0_irq,
    input logic [IRQ_W-1:0]                uart1_irq
);

    AST_IDX_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !port_sel) |=> (idx_q == $past(wdata)));   // R2

    AST_STEP_SATURATES: assert property (@(posedge clk) disable iff (rst)
        (step_q == 2'd2) |=> (step_q == 2'd2));   // R3

    AST_BAD_IDX_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && port_sel && idx_q > 8'd2) |-> (rdata == 8'h00));   // R4

    AST_BAD_IDX_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && port_sel && idx_q > 8'd2) |=> $stable(regs_q));   // R4

    AST_IDE_CTL_OFFSET: assert property (@(posedge clk) disable iff (rst)
        ide_ctl_base == ide_base + 16'h0206);   // R6

    AST_UART_IRQ_RANGE: assert property (@(posedge clk) disable iff (rst)
        (uart0_irq == 4'd3 || uart0_irq == 4'd4) && (uart1_irq == 4'd3 || uart1_irq == 4'd4));   // R8

    AST_DEC_LAG: assert property (@(posedge clk) disable iff (rst)
        fdc_en == $past(regs_q[0][3]));   // R9

    AST_BOTH_IS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && port_sel) |=> (step_q == $past(step_q)));   // R10

endmodule

bind sio_cfg_unit sio_cfg_checker u_chk (
    .clk(clk), .rst(rst), .port_sel(port_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .regs_q(regs_q), .idx_q(idx_q), .step_q(step_q),
    .fdc_en(fdc_en), .ide_base(ide_base), .ide_ctl_base(ide_ctl_base),
    .uart0_irq(uart0_irq), .uart1_irq(uart1_irq)
);

// File: tb/sio_cfg_unit_test.sv
`timescale 1ns/1ps
module sio_cfg_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  strap = 5'd1;
    logic        port_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        par_en, uart0_en, uart1_en, fdc_en, ide_en;
    logic [15:0] par_base, uart0_base, uart1_base, fdc_base, ide_base, ide_ctl_base;
    logic [3:0]  par_irq, uart0_irq, uart1_irq, fdc_irq, ide_irq;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    sio_cfg_unit uut (
        .clk(clk), .rst(rst), .strap(strap), .port_sel(port_sel),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
        .par_en(par_en), .par_base(par_base), .par_irq(par_irq),
        .uart0_en(uart0_en), .uart0_base(uart0_base), .uart0_irq(uart0_irq),
        .uart1_en(uart1_en), .uart1_base(uart1_base), .uart1_irq(uart1_irq),
        .fdc_en(fdc_en), .fdc_base(fdc_base), .fdc_irq(fdc_irq),
        .ide_en(ide_en), .ide_base(ide_base), .ide_ctl_base(ide_ctl_base),
        .ide_irq(ide_irq)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset(input logic [4:0] s);
        @(negedge clk);
        rst = 1'b1; strap = s;
        @(posedge clk); @(posedge clk);
        #1 rst = 1'b0;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        port_sel = sel; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [7:0] d);
        @(negedge clk);
        port_sel = sel; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk);
        #1 rd_en = 1'b0;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset_strap1();
        logic [7:0] v;
        do_reset(5'd1);
        check("R5", "strap1 fdc_base", fdc_base, 16'h03F0);
        check("R5", "strap1 ide_en", {15'd0, ide_en}, 16'd1);
        check("R7", "strap1 par_base", par_base, 16'h03BC);
        check("R7", "strap1 par_irq", {12'd0, par_irq}, 16'd7);
        check("R8", "strap1 uart0_base", uart0_base, 16'h03F8);
        check("R8", "strap1 uart0_irq", {12'd0, uart0_irq}, 16'd4);
        check("R8", "strap1 uart1_base", uart1_base, 16'h02F8);
        check("R8", "strap1 uart1_irq", {12'd0, uart1_irq}, 16'd3);
        check("R6", "fdc_irq", {12'd0, fdc_irq}, 16'd6);
        check("R6", "ide_irq", {12'd0, ide_irq}, 16'd14);
        check("R6", "ide_ctl_base", ide_ctl_base, 16'h03F6);
        rd(1'b0, v); check("R3", "id read 1", {8'd0, v}, 16'h0088);
        rd(1'b0, v); check("R3", "id read 2", {8'd0, v}, 16'h0000);
        rd(1'b1, v); check("R5", "strap1 enable reg", {8'd0, v}, 16'h004F);
        rd(1'b0, v); check("R3", "id read 3 index", {8'd0, v}, 16'h0000);
        rd(1'b0, v); check("R3", "id read 4 saturate", {8'd0, v}, 16'h0000);
        wr(1'b0, 8'd1); rd(1'b1, v); check("R5", "strap1 address reg", {8'd0, v}, 16'h0011);
        rd(1'b0, v); check("R2", "index readback 1", {8'd0, v}, 16'h0001);
        wr(1'b0, 8'd2); rd(1'b1, v); check("R5", "strap1 power reg", {8'd0, v}, 16'h0000);
    endtask

    task automatic t_reset_strap31();
        logic [7:0] v;
        do_reset(5'd31);
        check("R5", "strap31 par_en", {15'd0, par_en}, 16'd0);
        check("R5", "strap31 fdc_en", {15'd0, fdc_en}, 16'd0);
        rd(1'b1, v); check("R5", "strap31 enable reg", {8'd0, v}, 16'h0000);
        wr(1'b0, 8'd1); rd(1'b1, v); check("R5", "strap31 address reg", {8'd0, v}, 16'h0010);
        wr(1'b0, 8'd2); rd(1'b1, v); check("R5", "strap31 power reg", {8'd0, v}, 16'h0002);
        rd(1'b0, v); check("R3", "after index write no signature", {8'd0, v}, 16'h0002);
    endtask

    task automatic t_enable_decode();
        wr(1'b0, 8'd0);
        wr(1'b1, 8'hA9);
        check("R9", "fdc_base before lag edge", fdc_base, 16'h03F0);
        settle();
        check("R9", "fdc_base after lag edge", fdc_base, 16'h0370);
        check("R6", "ide_en cleared", {15'd0, ide_en}, 16'd0);
        check("R6", "ide_base high", ide_base, 16'h0170);
        check("R6", "ide_ctl_base high", ide_ctl_base, 16'h0376);
        check("R6", "uart enables", {14'd0, uart1_en, uart0_en}, 16'd0);
        check("R6", "par_en", {15'd0, par_en}, 16'd1);
    endtask

    task automatic t_parallel();
        wr(1'b0, 8'd2); wr(1'b1, 8'h08);
        wr(1'b0, 8'd1); wr(1'b1, 8'h00); settle();
        check("R7", "code0 pw3=1 base", par_base, 16'h0378);
        check("R7", "code0 pw3=1 irq", {12'd0, par_irq}, 16'd7);
        wr(1'b0, 8'd2); wr(1'b1, 8'h00); settle();
        check("R7", "code0 pw3=0 irq", {12'd0, par_irq}, 16'd5);
        wr(1'b0, 8'd1); wr(1'b1, 8'h02); settle();
        check("R7", "code2 base", par_base, 16'h0278);
        check("R7", "code2 irq", {12'd0, par_irq}, 16'd5);
        wr(1'b1, 8'h03); settle();
        check("R7", "code3 base", par_base, 16'h0000);
        check("R7", "code3 irq", {12'd0, par_irq}, 16'd0);
    endtask

    task automatic t_uart();
        wr(1'b0, 8'd1); wr(1'b1, 8'h78); settle();
        check("R8", "u0 code2 k1 base", uart0_base, 16'h0338);
        check("R8", "u0 code2 irq", {12'd0, uart0_irq}, 16'd4);
        check("R8", "u1 code3 k1 base", uart1_base, 16'h0238);
        check("R8", "u1 code3 irq", {12'd0, uart1_irq}, 16'd3);
        wr(1'b1, 8'hF8); settle();
        check("R8", "u0 code2 k3 base", uart0_base, 16'h0220);
        check("R8", "u1 code3 k3 base", uart1_base, 16'h0228);
        wr(1'b1, 8'h9C); settle();
        check("R8", "u0 code3 k2 base", uart0_base, 16'h02E0);
        check("R8", "u1 code1 base", uart1_base, 16'h02F8);
    endtask

    task automatic t_bad_index();
        logic [7:0] v;
        wr(1'b0, 8'd5);
        wr(1'b1, 8'hFF);
        rd(1'b1, v); check("R4", "bad index data read", {8'd0, v}, 16'h0000);
        rd(1'b0, v); check("R1", "index port returns index", {8'd0, v}, 16'h0005);
        wr(1'b0, 8'd0); rd(1'b1, v); check("R4", "enable reg untouched", {8'd0, v}, 16'h00A9);
        wr(1'b0, 8'd1); rd(1'b1, v); check("R4", "address reg untouched", {8'd0, v}, 16'h009C);
        wr(1'b0, 8'd2); rd(1'b1, v); check("R4", "power reg untouched", {8'd0, v}, 16'h0000);
    endtask

    task automatic t_both_strobes();
        logic [7:0] v;
        @(negedge clk);
        port_sel = 1'b0; wdata = 8'd1; wr_en = 1'b1; rd_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0; rd_en = 1'b0;
        rd(1'b0, v); check("R10", "both strobes wrote index", {8'd0, v}, 16'h0001);
        @(negedge clk);
        port_sel = 1'b1; wdata = 8'h01; wr_en = 1'b1; rd_en = 1'b1;
        @(posedge clk);
        #1 wr_en = 1'b0; rd_en = 1'b0;
        settle();
        check("R10", "both strobes wrote data", par_base, 16'h03BC);
    endtask

    initial begin
        t_reset_strap1();
        t_reset_strap31();
        t_enable_decode();
        t_parallel();
        t_uart();
        t_bad_index();
        t_both_strobes();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #500000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule